// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block produces the timing for a serial audio port: a bit clock, a transmit frame clock and a receive frame clock. One clock configuration word programs it. In master mode it derives every clock by counting the master audio clock, which is also its only clock. The bit-clock divider and the two frame lengths are held as value minus one. In slave mode it captures bit and frame clocks supplied from outside, which must already be synchronous to the master clock, and hands them on one cycle later.

Each frame clock can be inverted separately. A one-cycle sample-edge strobe marks the bit-clock transition that receiving logic should use, and configuration bit 26 selects whether that is the rising or the falling transition. A frame length written during a frame takes effect only when that frame ends. A divider written during operation takes effect only at a bit where the transmit and receive frames both end. No frame is ever cut short.

The configuration port carries bits 27:0 of the 32-bit clock register. Bits 31:28 of that register hold nothing.

Top module: `sac_clkgen`

## Requirements
- R1: While reset is held, bclk_o is 0, sample_edge_o is 0, tx_fs_o equals configuration bit 24 and rx_fs_o equals configuration bit 25.
- R2: In master mode (bit 27 = 0) the divider field in bits 23:16 holds F, and the bit-clock period is D = F+1 master cycles, with F = 0 treated as 1. Each period is high for ceil(D/2) cycles, then low. The first clock edge after reset starts a high phase.
- R3: The transmit frame field in bits 7:0 holds G, and a transmit frame lasts L = G+1 bit periods. The uninverted transmit frame clock is low for the first floor(L/2) bits and high for the rest. It changes only together with a rising edge of bclk_o.
- R4: The receive frame field in bits 15:8 sets the receive frame length in the same way as R3, independently of the transmit length.
- R5: Bit 24 = 1 inverts tx_fs_o and bit 25 = 1 inverts rx_fs_o. An inversion takes effect in the same cycle it is written, in both modes.
- R6: sample_edge_o is high for exactly the one cycle in which bclk_o shows a new level. With bit 26 = 1 this is a rising transition, and with bit 26 = 0 a falling one.
- R7: In slave mode (bit 27 = 1), bclk_o, the uninverted tx_fs_o and the uninverted rx_fs_o equal ext_bclk_i, ext_tx_fs_i and ext_rx_fs_i as sampled at the previous clock edge.
- R8: A divider or frame-length value written during a frame does not change the output until the current frame ends. A new frame length applies from the next frame of its own direction. A new divider applies from the first bit at which both frames end together.
- R9: On a change from slave to master mode, generation restarts from bit 0 of both frames with the configuration present at that edge, as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released away from a clock edge |
| clk_cfg_i | input | 28 | Clock configuration word (mode, edge select, inversions, divider, frame lengths) |
| ext_bclk_i | input | 1 | External bit clock used in slave mode |
| ext_tx_fs_i | input | 1 | External transmit frame clock used in slave mode |
| ext_rx_fs_i | input | 1 | External receive frame clock used in slave mode |
| bclk_o | output | 1 | Bit clock |
| tx_fs_o | output | 1 | Transmit frame clock after optional inversion |
| rx_fs_o | output | 1 | Receive frame clock after optional inversion |
| sample_edge_o | output | 1 | One-cycle strobe on the selected bit-clock transition |

## Verification
On every cycle the assertions check four things: the sample strobe lines up with a real transition of the selected direction, no bit-clock level in master mode outlasts half the largest period, the frame clocks move only with a rising bit clock, and slave mode forwards the external clocks with one cycle of delay. The exact period and duty of the bit clock, and the split of each frame into low and high halves, appear only in the bench's scenarios, which compare every cycle with a model. The same holds for odd divider and length values, a divider field of zero, and deferral of a mid-frame reprogramming to the frame boundary. The restart after leaving slave mode and the immediate effect of an inversion are also covered only by the bench.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned CFG_W = 4 + DIV_W + 2 * LEN_W;

  // Field order matches the register bit positions, high to low.
  typedef struct packed {
    logic             slave;
    logic             rise_smp;
    logic             rx_inv;
    logic             tx_inv;
    logic [DIV_W-1:0] div_m1;
    logic [LEN_W-1:0] rx_len_m1;
    logic [LEN_W-1:0] tx_len_m1;
  } clk_cfg_t;
endpackage

// File: rtl/sac_bit_divider.sv
module sac_bit_divider #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         fresh_i,
  input  logic         reload_i,
  input  logic [W-1:0] div_m1_i,
  input  logic         ext_bclk_i,
  output logic         bclk_q_o,
  output logic         bit_start_o,
  output logic         bit_end_o
);
  logic [W-1:0] cnt_q, cnt_d, shadow_q, shadow_d, dm_raw, dm;
  logic         bclk_d;

  always_comb begin
    dm_raw      = fresh_i ? div_m1_i : shadow_q;
    dm          = (dm_raw == '0) ? W'(1) : dm_raw;
    bit_start_o = run_i & (cnt_q == '0);
    bit_end_o   = run_i & (cnt_q == dm);
    cnt_d       = cnt_q;
    shadow_d    = shadow_q;
    bclk_d      = bclk_q_o;
    if (!run_i) begin
      cnt_d  = '0;
      bclk_d = ext_bclk_i;
    end else begin
      cnt_d  = bit_end_o ? '0 : cnt_q + W'(1);
      bclk_d = (cnt_q <= (dm >> 1));
    end
    if (run_i && (fresh_i || reload_i)) shadow_d = div_m1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      bclk_q_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      bclk_q_o <= bclk_d;
    end
  end
endmodule

// File: rtl/sac_frame_gen.sv
module sac_frame_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         fresh_i,
  input  logic         bit_start_i,
  input  logic         bit_end_i,
  input  logic [W-1:0] len_m1_i,
  input  logic         ext_fs_i,
  output logic         fs_q_o,
  output logic         frame_end_o
);
  logic [W-1:0] idx_q, idx_d, shadow_q, shadow_d, lm;
  logic [W:0]   half;
  logic         last, fs_d;

  always_comb begin
    lm          = fresh_i ? len_m1_i : shadow_q;
    half        = ({1'b0, lm} + (W+1)'(1)) >> 1;
    last        = (idx_q == lm);
    frame_end_o = bit_end_i & last;
    idx_d       = idx_q;
    fs_d        = fs_q_o;
    shadow_d    = shadow_q;
    if (!run_i) begin
      idx_d = '0;
      fs_d  = ext_fs_i;
    end else begin
      if (bit_end_i)   idx_d = last ? '0 : idx_q + W'(1);
      if (bit_start_i) fs_d  = ({1'b0, idx_q} >= half);
    end
    if (run_i && (fresh_i || frame_end_o)) shadow_d = len_m1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      shadow_q <= '0;
      fs_q_o   <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      shadow_q <= shadow_d;
      fs_q_o   <= fs_d;
    end
  end
endmodule

// File: rtl/sac_clkgen.sv
module sac_clkgen
  import sac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] clk_cfg_i,
  input  logic             ext_bclk_i,
  input  logic             ext_tx_fs_i,
  input  logic             ext_rx_fs_i,
  output logic             bclk_o,
  output logic             tx_fs_o,
  output logic             rx_fs_o,
  output logic             sample_edge_o
);
  localparam int unsigned NLANE = 2;

  clk_cfg_t               cfg;
  logic                   run, fresh, primed_q, primed_d;
  logic                   bclk_q, bclk_dly_q, bclk_dly_d;
  logic                   bit_start, bit_end, div_reload;
  logic [NLANE-1:0]       lane_ext, lane_fs, lane_end;
  logic [LEN_W-1:0]       lane_len [NLANE];

  assign cfg         = clk_cfg_t'(clk_cfg_i);
  assign run         = ~cfg.slave;
  assign fresh       = ~primed_q;
  assign lane_ext    = {ext_rx_fs_i, ext_tx_fs_i};
  assign lane_len[0] = cfg.tx_len_m1;
  assign lane_len[1] = cfg.rx_len_m1;
  assign div_reload  = &lane_end;

  sac_bit_divider #(.W(DIV_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .fresh_i     (fresh),
    .reload_i    (div_reload),
    .div_m1_i    (cfg.div_m1),
    .ext_bclk_i  (ext_bclk_i),
    .bclk_q_o    (bclk_q),
    .bit_start_o (bit_start),
    .bit_end_o   (bit_end)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    sac_frame_gen #(.W(LEN_W)) u_frame (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .fresh_i     (fresh),
      .bit_start_i (bit_start),
      .bit_end_i   (bit_end),
      .len_m1_i    (lane_len[g]),
      .ext_fs_i    (lane_ext[g]),
      .fs_q_o      (lane_fs[g]),
      .frame_end_o (lane_end[g])
    );
  end

  always_comb begin
    primed_d   = run;
    bclk_dly_d = bclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q   <= 1'b0;
      bclk_dly_q <= 1'b0;
    end else begin
      primed_q   <= primed_d;
      bclk_dly_q <= bclk_dly_d;
    end
  end

  assign bclk_o        = bclk_q;
  assign tx_fs_o       = lane_fs[0] ^ cfg.tx_inv;
  assign rx_fs_o       = lane_fs[1] ^ cfg.rx_inv;
  assign sample_edge_o = cfg.rise_smp ? (bclk_q & ~bclk_dly_q) : (~bclk_q & bclk_dly_q);
endmodule

// File: rtl/sac_clkgen_chk.sv
module sac_clkgen_chk
  import sac_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] clk_cfg_i,
  input logic             ext_bclk_i,
  input logic             ext_tx_fs_i,
  input logic             ext_rx_fs_i,
  input logic             bclk_o,
  input logic             tx_fs_o,
  input logic             rx_fs_o,
  input logic             sample_edge_o
);
  localparam int unsigned MAX_LVL = 2 ** (DIV_W - 1);
  localparam int unsigned CW      = DIV_W + 1;

  clk_cfg_t        cf;
  logic            master, armed_q, prev_q;
  logic [CW-1:0]   lvl_q;

  assign cf     = clk_cfg_t'(clk_cfg_i);
  assign master = ~cf.slave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
      lvl_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= bclk_o;
      if (!master || (bclk_o != prev_q)) lvl_q <= CW'(1);
      else if (lvl_q != '1)              lvl_q <= lvl_q + CW'(1);
    end
  end

  // R2
  bclk_level_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= CW'(MAX_LVL));

  // R6
  sample_edge_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sample_edge_o) |-> ((bclk_o != $past(bclk_o)) && (bclk_o == cf.rise_smp)));

  // R3
  tx_fs_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && master && $past(master) && ((tx_fs_o ^ cf.tx_inv) != $past(tx_fs_o ^ cf.tx_inv)))
      |-> $rose(bclk_o));

  // R4
  rx_fs_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && master && $past(master) && ((rx_fs_o ^ cf.rx_inv) != $past(rx_fs_o ^ cf.rx_inv)))
      |-> $rose(bclk_o));

  // R7
  slave_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !master && !$past(master)) |->
      ((bclk_o == $past(ext_bclk_i)) && ((tx_fs_o ^ cf.tx_inv) == $past(ext_tx_fs_i))
       && ((rx_fs_o ^ cf.rx_inv) == $past(ext_rx_fs_i))));
endmodule

bind sac_clkgen sac_clkgen_chk u_chk (.*);

// File: tb/tb_sac_clkgen.sv
module tb_sac_clkgen;
  logic        clk, rst_ni;
  logic [27:0] cfg;
  logic        ext_bclk, ext_tx, ext_rx;
  logic        bclk_o, tx_fs_o, rx_fs_o, sample_edge_o;
  int          n_chk, n_fail;
  logic        inv_t;

  localparam logic [27:0] VEC [5] = '{28'h003_0303, 28'h404_0401, 28'h100_0007,
                                      28'h601_0F02, 28'h306_0509};

  sac_clkgen dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_cfg_i(cfg), .ext_bclk_i(ext_bclk),
    .ext_tx_fs_i(ext_tx), .ext_rx_fs_i(ext_rx), .bclk_o(bclk_o), .tx_fs_o(tx_fs_o),
    .rx_fs_o(rx_fs_o), .sample_edge_o(sample_edge_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_bclk(int k, int dm);
    if (k <= 0) return 1'b0;
    return ((k - 1) % (dm + 1)) <= (dm / 2);
  endfunction

  function automatic logic m_fs(int k, int dm, int lm);
    int n;
    if (k <= 0) return 1'b0;
    n = (k - 1) / (dm + 1);
    return (n % (lm + 1)) >= ((lm + 1) / 2);
  endfunction

  // k = clock edges since the segment started; model from R2..R6
  task automatic chk_master(input int k, input logic [27:0] c, input string pfx);
    int dm, tl, rl;
    logic b, p;
    dm = (c[23:16] == 8'd0) ? 1 : int'(c[23:16]);
    rl = int'(c[15:8]);
    tl = int'(c[7:0]);
    b  = m_bclk(k, dm);
    p  = m_bclk(k - 1, dm);
    chk({pfx, "R2 bit clock"}, bclk_o, b);
    chk({pfx, "R3 tx frame / R5 inversion"}, tx_fs_o, m_fs(k, dm, tl) ^ c[24]);
    chk({pfx, "R4 rx frame / R5 inversion"}, rx_fs_o, m_fs(k, dm, rl) ^ c[25]);
    chk({pfx, "R6 sample edge"}, sample_edge_o, c[26] ? (b & ~p) : (~b & p));
  endtask

  task automatic apply_reset(input logic [27:0] c);
    @(negedge clk);
    rst_ni = 1'b0;
    cfg = c;
    ext_bclk = 1'b0; ext_tx = 1'b0; ext_rx = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic logic vb(int i); return (i % 3) == 1; endfunction
  function automatic logic vt(int i); return ((i / 3) % 2) == 1; endfunction
  function automatic logic vr(int i); return ((i / 5) % 2) == 1; endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; inv_t = 1'b0;
    rst_ni = 1'b0;
    cfg = 28'h300_0000;
    ext_bclk = 1'b0; ext_tx = 1'b0; ext_rx = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state with both inversions set
    chk("R1 reset bclk", bclk_o, 1'b0);
    chk("R1 reset tx frame", tx_fs_o, 1'b1);
    chk("R1 reset rx frame", rx_fs_o, 1'b1);
    chk("R1 reset sample edge", sample_edge_o, 1'b0);

    // table walk: each vector from reset, compared against the model every cycle
    for (int v = 0; v < 5; v++) begin
      apply_reset(VEC[v]);
      for (int k = 1; k <= 200; k++) begin
        @(negedge clk);
        chk_master(k, VEC[v], "");
      end
    end

    // R8: divider and tx length rewritten mid-frame; old timing to edge 16
    apply_reset(28'h003_0303);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk_master(k, 28'h003_0303, "R8 ");
      if (k == 5) cfg = 28'h001_0305;
    end
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      chk_master(k, 28'h001_0305, "R8 ");
    end

    // R7: slave pass-through with rising-edge strobe; R5 inversion mid-stream
    cfg = 28'hC00_0000;
    ext_bclk = vb(0); ext_tx = vt(0); ext_rx = vr(0);
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      chk("R7 slave bclk", bclk_o, vb(i - 1));
      chk("R7 slave tx frame", tx_fs_o, vt(i - 1) ^ inv_t);
      chk("R7 slave rx frame", rx_fs_o, vr(i - 1) ^ inv_t);
      if (i >= 2) chk("R6 slave sample edge", sample_edge_o, vb(i - 1) & ~vb(i - 2));
      if (i == 12) begin
        cfg = 28'hF00_0000;
        inv_t = 1'b1;
        #1;
        chk("R5 immediate tx inversion", tx_fs_o, vt(11) ^ 1'b1);
        chk("R5 immediate rx inversion", rx_fs_o, vr(11) ^ 1'b1);
      end
      if (i < 24) begin
        ext_bclk = vb(i); ext_tx = vt(i); ext_rx = vr(i);
      end
    end

    // R9: back to master, restart from bit 0 with the new word
    cfg = 28'h002_0102;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      chk_master(k, 28'h002_0102, "R9 ");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule